// File: doc/BRIEF.md
# Queued Serial Transmit Feeder

This block sits between a register bus and the data-register side of a UART-style transmitter. Instead of writing one frame at a time, software fills a sixteen-entry transmit queue, sets a frame count and turns on queue mode. The block then offers one queue entry at a time to the transmitter through a valid/ready handshake. An internal pointer selects the entry on offer, and a pending counter tracks how many frames are still to go.

Each half of the queue (entries 0-7 and 8-15) has an empty flag, and each flag has its own interrupt enable. A one-shot wrap enable lets a run that reaches entry 15 start again at entry 0 with a fresh frame count, and hardware then clears the wrap enable. When queue mode is off, the block acts as a plain single-holding-register feeder, and the queue flags do not reach the interrupt.

Register map (word address on `regAddr`):

- Addresses 0-15 are the queue entries.
- Address 16 is control: bits [3:0] size, bit 4 wrap enable, bit 5 queue enable, bit 6 top-half interrupt enable, bit 7 bottom-half interrupt enable.
- Address 17 is the pointer, in bits [3:0].
- Address 18 is status: bit 0 top-half empty, bit 1 bottom-half empty, bit 2 transmit complete, bits [7:3] pending count.
- Address 19 is the single holding register.

Top module: `txq_feeder`

## Requirements
- R1: After reset the pointer and the pending count are 0, and both half-empty flags are 1, so status reads 7 while `txIdle` is high. Also, `frameValid` and `irq` are low and `txDone` is high.
- R2: A control write with bit 5 set loads the pending count with size+1, so size 0 sends 1 frame and size 15 sends 16 frames. Frames go out in ascending entry order, starting at the pointer, with one frame per handshake (`frameValid && frameReady` at a clock edge).
- R3: When wrap enable (control bit 4) is clear, a run stops once the pending count reaches 0 or entry 15 has been sent, whichever comes first. After that, `frameValid` stays low in queue mode.
- R4: The pointer advances by one per queue handshake and goes from 15 to 0. It holds otherwise. A write to address 17 changes it only while `testMode` is high.
- R5: Suppose entry 15 is sent while wrap enable is set. The pointer then goes to 0, the pending count reloads with size+1, and wrap enable reads back as 0. A run that ends before entry 15 leaves wrap enable set.
- R6: The top-half flag (status bit 0) sets when entry 7 is sent. The bottom-half flag (status bit 1) sets when entry 15 is sent. A write to any entry of a half clears that half's flag.
- R7: `irq` is high exactly when queue mode is on and at least one half-empty flag is set together with its enable (control bit 6 for the top half, bit 7 for the bottom half). When queue mode is off, `irq` is low.
- R8: In queue mode, `txDone` is high only when the pending count is 0 and `txIdle` is high. It stays low while any queued frame is still unsent.
- R9: With queue mode off, a write to address 19 presents that value on `frameData` with `frameValid` high. A handshake drops `frameValid` and raises `txDone` while `txIdle` is high.
- R10: While `frameValid` is high and `frameReady` is low, the offered frame, the pointer and `frameValid` all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| testMode | input | 1 | Allows pointer writes |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational on `regAddr` |
| frameValid | output | 1 | A frame is offered to the transmitter |
| frameData | output | 9 | Offered frame |
| frameReady | input | 1 | Transmitter accepts the offered frame |
| txIdle | input | 1 | Transmitter shifter is idle |
| txDone | output | 1 | Transmit complete |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the wrap: entry 15 must be handed off while wrap enable is set and the reloaded count must run past the bottom a second time. The stimulus gets there by placing the pointer near the bottom through test mode. It then sweeps start pointers against every size, which covers both ways a run can end: the count running out and the run hitting entry 15. For the half flags, a run stops just after entry 7 and the bench then toggles the individual enables, so each flag and its gating reach `irq` on their own.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Strobes handed from the control to the datapath.
  typedef struct packed {
    logic qMode;    // queue mode selected
    logic qActive;  // queue mode with frames still pending
  } txq_strobe_t;
endpackage

// File: rtl/txq_control.sv
module txq_control #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int ADDR_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 testMode,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic                 handoff,
  input  logic                 txIdle,
  input  logic                 dataFull,
  output txq_pkg::txq_strobe_t strobes,
  output logic [PTR_W-1:0]     rdPtr,
  output logic [DATA_W-1:0]    ctrlRdata,
  output logic                 irq,
  output logic                 txDone
);
  localparam int CNT_W  = PTR_W + 1;
  localparam int CTRL_W = PTR_W + 4;
  localparam int WRAP_B = PTR_W;
  localparam int QEN_B  = PTR_W + 1;
  localparam int TIE_B  = PTR_W + 2;
  localparam int BIE_B  = PTR_W + 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] ADDR_PTR  = ADDR_W'(DEPTH + 1);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(DEPTH + 2);
  localparam logic [PTR_W-1:0]  TOP_LAST  = PTR_W'(DEPTH / 2 - 1);
  localparam logic [PTR_W-1:0]  BOT_LAST  = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptrQ, sizeQ;
  logic [CNT_W-1:0] pendQ, reload, wrLoad;
  logic wrapQ, qEnQ, topIeQ, botIeQ, topEmptyQ, botEmptyQ;
  logic qActive, qHandoff, atBottom, ctrlWr, ptrWr, entryWr, upperHalf;
  logic unusedBits;

  assign unusedBits = &{1'b0, regWdata[DATA_W-1:CTRL_W]};

  assign qActive   = qEnQ && (pendQ != '0);
  assign qHandoff  = handoff && qActive;
  assign atBottom  = (ptrQ == BOT_LAST);
  assign ctrlWr    = regWe && (regAddr == ADDR_CTRL);
  assign ptrWr     = regWe && (regAddr == ADDR_PTR) && testMode;
  assign entryWr   = regWe && (regAddr < ADDR_CTRL);
  assign upperHalf = regAddr[PTR_W-1];
  assign reload    = {1'b0, sizeQ} + CNT_W'(1);
  assign wrLoad    = {1'b0, regWdata[PTR_W-1:0]} + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ      <= '0;
      pendQ     <= '0;
      sizeQ     <= '0;
      wrapQ     <= 1'b0;
      qEnQ      <= 1'b0;
      topIeQ    <= 1'b0;
      botIeQ    <= 1'b0;
      topEmptyQ <= 1'b1;
      botEmptyQ <= 1'b1;
    end else begin
      if (qHandoff) begin
        if (atBottom) begin
          ptrQ <= '0;
          if (wrapQ) begin
            pendQ <= reload;
            wrapQ <= 1'b0;
          end else begin
            pendQ <= '0;
          end
        end else begin
          ptrQ  <= ptrQ + 1'b1;
          pendQ <= pendQ - 1'b1;
        end
        if (ptrQ == TOP_LAST) topEmptyQ <= 1'b1;
        if (atBottom)         botEmptyQ <= 1'b1;
      end
      if (ptrWr) ptrQ <= regWdata[PTR_W-1:0];
      if (ctrlWr) begin
        sizeQ  <= regWdata[PTR_W-1:0];
        wrapQ  <= regWdata[WRAP_B];
        qEnQ   <= regWdata[QEN_B];
        topIeQ <= regWdata[TIE_B];
        botIeQ <= regWdata[BIE_B];
        if (regWdata[QEN_B]) pendQ <= wrLoad;
      end
      if (entryWr && !upperHalf) topEmptyQ <= 1'b0;
      if (entryWr &&  upperHalf) botEmptyQ <= 1'b0;
    end
  end

  assign strobes.qMode   = qEnQ;
  assign strobes.qActive = qActive;
  assign rdPtr           = ptrQ;

  assign txDone = txIdle && (qEnQ ? (pendQ == '0) : !dataFull);
  assign irq    = qEnQ && ((topEmptyQ && topIeQ) || (botEmptyQ && botIeQ));

  always_comb begin
    ctrlRdata = '0;
    if (regAddr == ADDR_CTRL)
      ctrlRdata = DATA_W'({botIeQ, topIeQ, qEnQ, wrapQ, sizeQ});
    else if (regAddr == ADDR_PTR)
      ctrlRdata = DATA_W'(ptrQ);
    else if (regAddr == ADDR_STAT)
      ctrlRdata = DATA_W'({pendQ, txDone, botEmptyQ, topEmptyQ});
  end
endmodule

// File: rtl/txq_datapath.sv
module txq_datapath #(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 9,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int ADDR_W  = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  txq_pkg::txq_strobe_t strobes,
  input  logic [PTR_W-1:0]     rdPtr,
  input  logic                 handoff,
  output logic                 frameValid,
  output logic [FRAME_W-1:0]   frameData,
  output logic                 dataFull,
  output logic [DATA_W-1:0]    dpRdata
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(DEPTH + 3);

  logic [FRAME_W-1:0] entries [DEPTH];
  logic [FRAME_W-1:0] holdQ;
  logic               unusedBits;

  assign unusedBits = &{1'b0, regWdata[DATA_W-1:FRAME_W]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   entries[i] <= '0;
      else if (regWe && regAddr == ADDR_W'(i))     entries[i] <= regWdata[FRAME_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ    <= '0;
      dataFull <= 1'b0;
    end else if (regWe && regAddr == ADDR_DATA) begin
      holdQ    <= regWdata[FRAME_W-1:0];
      dataFull <= 1'b1;
    end else if (handoff && !strobes.qMode) begin
      dataFull <= 1'b0;
    end
  end

  assign frameValid = strobes.qMode ? strobes.qActive : dataFull;
  assign frameData  = strobes.qMode ? entries[rdPtr] : holdQ;

  always_comb begin
    dpRdata = '0;
    if (regAddr < ADDR_CTRL)       dpRdata = DATA_W'(entries[regAddr[PTR_W-1:0]]);
    else if (regAddr == ADDR_DATA) dpRdata = DATA_W'(holdQ);
  end
endmodule

// File: rtl/txq_feeder.sv
module txq_feeder #(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 9,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               testMode,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               frameValid,
  output logic [FRAME_W-1:0] frameData,
  input  logic               frameReady,
  input  logic               txIdle,
  output logic               txDone,
  output logic               irq
);
  txq_pkg::txq_strobe_t strobes;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] ctrlRdata, dpRdata;
  logic              dataFull, handoff;

  assign handoff  = frameValid && frameReady;
  assign regRdata = ctrlRdata | dpRdata;

  txq_control #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .handoff(handoff), .txIdle(txIdle), .dataFull(dataFull),
    .strobes(strobes), .rdPtr(rdPtr), .ctrlRdata(ctrlRdata), .irq(irq), .txDone(txDone)
  );

  txq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .PTR_W(PTR_W),
                 .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .strobes(strobes), .rdPtr(rdPtr), .handoff(handoff), .frameValid(frameValid),
    .frameData(frameData), .dataFull(dataFull), .dpRdata(dpRdata)
  );
endmodule

// File: rtl/txq_feeder_chk.sv
module txq_feeder_chk #(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 9,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               frameValid,
  input logic               frameReady,
  input logic [FRAME_W-1:0] frameData,
  input logic               irq,
  input logic               handoff,
  input logic               qMode,
  input logic               qActive,
  input logic [ADDR_W-2:0]  rdPtr
);
  localparam logic [ADDR_W-2:0] LAST_ENTRY = (ADDR_W-1)'(DEPTH - 1);
  logic ptrWrite;
  assign ptrWrite = regWe && (regAddr == ADDR_W'(DEPTH + 1));

  // R3
  idle_no_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qMode && !qActive) |-> !frameValid);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (handoff && qMode && rdPtr != LAST_ENTRY && !ptrWrite) |=> rdPtr == $past(rdPtr) + 1'b1);

  // R5
  bottom_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (handoff && qMode && rdPtr == LAST_ENTRY && !ptrWrite) |=> rdPtr == '0);

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!handoff && !ptrWrite) |=> $stable(rdPtr));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !qMode |-> !irq);

  // R10
  hold_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !frameReady && !regWe) |=> (frameValid && $stable(frameData)));
endmodule

bind txq_feeder txq_feeder_chk #(.DEPTH(DEPTH), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .frameValid(frameValid),
  .frameReady(frameReady), .frameData(frameData), .irq(irq), .handoff(handoff),
  .qMode(strobes.qMode), .qActive(strobes.qActive), .rdPtr(rdPtr)
);

// File: tb/txq_feeder_tb.sv
`timescale 1ns/1ps
module txq_feeder_tb;
  logic        clk = 1'b0, rstN = 1'b0, testMode = 1'b0, regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWdata = '0, regRdata;
  logic        frameValid, frameReady = 1'b0, txIdle = 1'b1, txDone, irq;
  logic [8:0]  frameData;
  int checks = 0, fails = 0;

  txq_feeder u_dut (.clk(clk), .rstN(rstN), .testMode(testMode), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .frameValid(frameValid),
    .frameData(frameData), .frameReady(frameReady), .txIdle(txIdle), .txDone(txDone), .irq(irq));

  always #2 clk = ~clk;

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int entryVal(int i);
    return (i * 37 + 5) & 'h1ff;
  endfunction

  function automatic logic [15:0] ctrlWord(int size, bit wrap, bit qen, bit tie, bit bie);
    return 16'(size) | (16'(wrap) << 4) | (16'(qen) << 5) | (16'(tie) << 6) | (16'(bie) << 7);
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 5'(addr); regWdata = 16'(data);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int addr, output int v);
    regAddr = 5'(addr);
    #0.5;
    v = int'(regRdata);
  endtask

  task automatic setPtr(input int p);
    testMode = 1'b1; wr(17, p); testMode = 1'b0;
  endtask

  // Accept frames until frameValid drops; entries are expected in order from startIdx.
  task automatic drain(input int startIdx, output int n, output bit seqOk, output bit doneLow);
    n = 0; seqOk = 1'b1; doneLow = 1'b1;
    for (int c = 0; c < 64; c++) begin
      if (!frameValid) break;
      if (txDone) doneLow = 1'b0;
      if (int'(frameData) != entryVal((startIdx + n) % 16)) seqOk = 1'b0;
      frameReady = 1'b1;
      n++;
      @(negedge clk);
    end
    frameReady = 1'b0;
  endtask

  initial begin
    int v, n, expN;
    bit ok, dl;
    int starts[4] = '{0, 5, 8, 13};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!frameValid && !irq && txDone, "R1 outputs", {frameValid, irq, txDone}, 1);
    rd(17, v); check(v == 0, "R1 pointer", v, 0);
    rd(18, v); check(v == 7, "R1 status", v, 7);

    for (int i = 0; i < 16; i++) wr(i, entryVal(i));
    rd(18, v); check((v & 3) == 0, "R6 flags cleared by writes", v & 3, 0);

    // R2 / R3 / R4 / R8 sweep of start pointer against size
    for (int si = 0; si < 4; si++) begin
      for (int size = 0; size < 16; size++) begin
        setPtr(starts[si]);
        wr(16, ctrlWord(size, 0, 1, 0, 0));
        drain(starts[si], n, ok, dl);
        expN = (size + 1 < 16 - starts[si]) ? size + 1 : 16 - starts[si];
        if (size + 1 <= 16 - starts[si]) check(n == expN, "R2 frame count", n, expN);
        else check(n == expN, "R3 stop at bottom", n, expN);
        check(ok, "R2 frame order", ok, 1);
        check(dl, "R8 done low while sending", dl, 1);
        rd(17, v); check(v == (starts[si] + expN) % 16, "R4 pointer after run", v, (starts[si] + expN) % 16);
        check(txDone, "R8 done after run", txDone, 1);
      end
    end
    rd(18, v); check(((v >> 3) & 31) == 0, "R3 pending zero", (v >> 3) & 31, 0);

    // R5 wrap cases
    setPtr(12); wr(16, ctrlWord(5, 1, 1, 0, 0));
    drain(12, n, ok, dl);
    check(n == 10 && ok, "R5 wrap count/order", n, 10);
    rd(17, v); check(v == 6, "R5 pointer after wrap", v, 6);
    rd(16, v); check(((v >> 4) & 1) == 0, "R5 wrap self-clear", (v >> 4) & 1, 0);
    setPtr(12); wr(16, ctrlWord(15, 1, 1, 0, 0));
    drain(12, n, ok, dl);
    check(n == 20 && ok, "R5 wrap then bottom stop", n, 20);
    setPtr(0); wr(16, ctrlWord(3, 1, 1, 0, 0));
    drain(0, n, ok, dl);
    check(n == 4, "R5 no wrap before bottom", n, 4);
    rd(16, v); check(((v >> 4) & 1) == 1, "R5 wrap kept", (v >> 4) & 1, 1);

    // R4 pointer write ignored outside test mode
    rd(17, v);
    wr(17, 9);
    begin int w; rd(17, w); check(w == v, "R4 pointer write blocked", w, v); end

    // R6 / R7 flags and interrupt gating
    for (int i = 0; i < 16; i++) wr(i, entryVal(i));
    setPtr(0); wr(16, ctrlWord(7, 0, 1, 0, 0));
    drain(0, n, ok, dl);
    rd(18, v); check((v & 3) == 1, "R6 top flag after entry 7", v & 3, 1);
    check(!irq, "R7 irq masked", irq, 0);
    wr(16, ctrlWord(0, 0, 1, 0, 1));
    check(!irq, "R7 other enable only", irq, 0);
    wr(16, ctrlWord(0, 0, 1, 1, 0));
    check(irq, "R7 top enable", irq, 1);
    wr(3, entryVal(3));
    check(!irq, "R7 irq after top refill", irq, 0);
    rd(18, v); check((v & 1) == 0, "R6 top cleared by write", v & 1, 0);
    drain(8, n, ok, dl);
    check(n == 1 && ok, "R2 single frame", n, 1);
    wr(16, ctrlWord(7, 0, 1, 1, 0));
    drain(9, n, ok, dl);
    check(n == 7 && ok, "R3 run to bottom", n, 7);
    rd(18, v); check((v & 3) == 2, "R6 bottom flag after entry 15", v & 3, 2);
    check(!irq, "R7 bottom not enabled", irq, 0);
    wr(16, ctrlWord(0, 0, 1, 0, 1));
    check(irq, "R7 bottom enable", irq, 1);
    check(frameValid, "R10 queue frame offered", frameValid, 1);
    repeat (3) @(negedge clk);
    check(frameValid && int'(frameData) == entryVal(0), "R10 queue hold", frameData, entryVal(0));
    rd(17, v); check(v == 0, "R10 pointer held", v, 0);
    wr(16, ctrlWord(0, 0, 0, 1, 1));
    check(!irq, "R7 queue mode off", irq, 0);

    // R9 single register mode
    wr(19, 'h0ab);
    check(frameValid && frameData == 9'h0ab, "R9 holding offered", frameData, 'h0ab);
    check(!txDone, "R9 done low while full", txDone, 0);
    repeat (2) @(negedge clk);
    check(frameValid && frameData == 9'h0ab, "R10 holding kept", frameData, 'h0ab);
    frameReady = 1'b1; @(negedge clk); frameReady = 1'b0;
    check(!frameValid && txDone, "R9 taken", {frameValid, txDone}, 1);
    txIdle = 1'b0; #0.5;
    check(!txDone, "R8 done needs idle shifter", txDone, 0);
    txIdle = 1'b1;

    finishRun();
  end
endmodule